// File: doc/BRIEF.md
# Interrupt-Capable GPIO Register Bank

This block is a single bank of general-purpose pins behind a small register bus. Software sets each pin's direction and output level and reads back the synchronized input level. Each pin can also flag an interrupt on a rising edge, a falling edge, either edge, a high level or a low level. Latched events are kept in a raw status register, gated by a per-pin enable into a masked view, and ORed into one interrupt line.

Software clears status by writing ones. The bank also holds pad settings for every pin: a pull enable, a pull direction and a 3-bit drive code. It presents these as pad-facing outputs. The bus is single-cycle. A write takes effect at the clock edge that samples it. Read data appears registered on the following cycle and is zero when no read is made.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset every register, every pad-facing output, `irq` and `bus_rdata` are 0.
- R2: Offset 0x04 holds the output levels and drives `pin_out`. Offset 0x08 holds the output enables (1 = drive) and drives `pin_oe`. Both read back what was written.
- R3: Offset 0x00 reads each pin's input after a two-flop synchronizer. Writes to 0x00, 0x1C and 0x20 change nothing.
- R4: When a pin's bit at 0x0C is 0 (edge mode) and its bit at 0x10 is 0, its bit at 0x14 picks the edge that latches status: 1 = rising, 0 = falling. An edge is a change of the synchronized value from its previous sample.
- R5: When a pin is in edge mode and its bit at 0x10 is 1, both rising and falling edges latch status, whatever the bit at 0x14 holds.
- R6: When a pin's bit at 0x0C is 1 (level mode), status is set on every cycle in which the synchronized input equals the bit at 0x14 (1 = active high, 0 = active low). A clear therefore has no lasting effect while the level stays active. Status stays latched after the level goes away, until it is cleared.
- R7: Writing to offset 0x24 clears the raw status bits written as 1. Bits written as 0 keep their value. Offset 0x24 reads as 0.
- R8: When a clear and a newly detected event hit the same bit in the same cycle, the bit stays set.
- R9: Offset 0x1C reads raw status. Offset 0x20 reads raw status AND the enable register at 0x18. `irq` is the OR of the masked bits, one cycle after the status.
- R10: Offset 0x38 holds pull enables and 0x34 pull directions (1 = up). `pad_pull_up` is enable AND direction, and `pad_pull_dn` is enable AND NOT direction. With the enable at 0, neither is asserted.
- R11: Offsets 0x58, 0x5C and 0x60 hold bit 0, bit 1 and bit 2 of each pin's drive code. Pin i's code appears at `pad_drive[3i+2:3i]` (current = (code+1)·2 mA).
- R12: Reads of unmapped or misaligned addresses (low two bits not 00) return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Registered read data, valid the cycle after a read |
| pin_in | input | PINS | Asynchronous pin inputs |
| pin_out | output | PINS | Output levels |
| pin_oe | output | PINS | Output enables |
| pad_pull_up | output | PINS | Pull-up active per pin |
| pad_pull_dn | output | PINS | Pull-down active per pin |
| pad_drive | output | 3*PINS | Drive code per pin, 3 bits each |
| irq | output | 1 | Combined masked interrupt |

## Verification
The collision that matters is a write-one clear arriving in the same cycle that event detection sets the same status bit. The bench provokes it directly. It raises a rising-edge pin and times the clear write so that the bus edge coincides with the edge at which the synchronized level first differs from its previous sample. The raw status read afterwards must still show the bit, and `irq` must stay high. A level-mode pin gives the same collision on every cycle it is active. The bench judges it by reading status after clears, both with the level held and after the level is released. Random traffic then mixes pin toggles with clears and reads against a cycle model, so further coincidences are compared against it every cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // word indices (byte offset / 4) of the read-only and write-only slots
  localparam int W_DIN = 0;
  localparam int W_RAW = 7;
  localparam int W_MSK = 8;
  localparam int W_CLR = 9;

  // writable bit-planes, one bit per pin each
  localparam int NPLANE  = 11;
  localparam int PL_DOUT = 0;
  localparam int PL_OE   = 1;
  localparam int PL_LVL  = 2;
  localparam int PL_DUAL = 3;
  localparam int PL_POL  = 4;
  localparam int PL_MASK = 5;
  localparam int PL_PDIR = 6;
  localparam int PL_PEN  = 7;
  localparam int PL_DS0  = 8;
  localparam int PL_DS1  = 9;
  localparam int PL_DS2  = 10;

  localparam int PLANE_WORD [NPLANE] = '{1, 2, 3, 4, 5, 6, 13, 14, 22, 23, 24};

  localparam int DRV_BITS = 3;
endpackage

// File: rtl/gpio_plane_reg.sv
module gpio_plane_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] level,
  input  logic [W-1:0] dual,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt,
  output logic [W-1:0] stat_q
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    assign rise     = sync_i[i] & ~prev_i[i];
    assign fall     = ~sync_i[i] & prev_i[i];
    assign lvl_hit  = ~(sync_i[i] ^ pol[i]);
    assign edge_hit = dual[i] ? (rise | fall) : (pol[i] ? rise : fall);
    assign evt[i]   = level[i] ? lvl_hit : edge_hit;
  end

  // a fresh event outranks a clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr) | evt;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [PINS-1:0]          bus_wdata,
  output logic [PINS-1:0]          bus_rdata,
  input  logic [PINS-1:0]          pin_in,
  output logic [PINS-1:0]          pin_out,
  output logic [PINS-1:0]          pin_oe,
  output logic [PINS-1:0]          pad_pull_up,
  output logic [PINS-1:0]          pad_pull_dn,
  output logic [PINS*DRV_BITS-1:0] pad_drive,
  output logic                     irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned, wr_go, rd_go;
  logic [PINS-1:0]   plane_q [NPLANE];
  logic [PINS-1:0]   sync_q, prev_q, evt, stat_q, clr;
  logic [PINS-1:0]   lvl_q, dual_q, pol_q, mask_q;
  logic [PINS-1:0]   rd_val;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_go   = bus_sel & bus_wr & aligned;
  assign rd_go   = bus_sel & ~bus_wr;

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    logic hit;
    assign hit = wr_go && (int'(word) == PLANE_WORD[p]);
    gpio_plane_reg #(.W(PINS)) u_reg (
      .clk (clk),
      .rst (rst),
      .we  (hit),
      .d   (bus_wdata),
      .q   (plane_q[p])
    );
  end

  assign lvl_q  = plane_q[PL_LVL];
  assign dual_q = plane_q[PL_DUAL];
  assign pol_q  = plane_q[PL_POL];
  assign mask_q = plane_q[PL_MASK];

  gpio_in_sync #(.W(PINS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin    (pin_in),
    .sync_q (sync_q),
    .prev_q (prev_q)
  );

  assign clr = (wr_go && int'(word) == W_CLR) ? bus_wdata : '0;

  gpio_irq_detect #(.W(PINS)) u_det (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_q),
    .prev_i (prev_q),
    .level  (lvl_q),
    .dual   (dual_q),
    .pol    (pol_q),
    .clr    (clr),
    .evt    (evt),
    .stat_q (stat_q)
  );

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      if (int'(word) == W_DIN) rd_val = sync_q;
      if (int'(word) == W_RAW) rd_val = stat_q;
      if (int'(word) == W_MSK) rd_val = stat_q & mask_q;
      for (int p = 0; p < NPLANE; p++)
        if (int'(word) == PLANE_WORD[p]) rd_val = plane_q[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_go ? rd_val : '0;
      irq       <= |(stat_q & mask_q);
    end
  end

  assign pin_out     = plane_q[PL_DOUT];
  assign pin_oe      = plane_q[PL_OE];
  assign pad_pull_up = plane_q[PL_PEN] & plane_q[PL_PDIR];
  assign pad_pull_dn = plane_q[PL_PEN] & ~plane_q[PL_PDIR];

  for (genvar i = 0; i < PINS; i++) begin : g_drv
    assign pad_drive[DRV_BITS*i +: DRV_BITS] =
      {plane_q[PL_DS2][i], plane_q[PL_DS1][i], plane_q[PL_DS0][i]};
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PINS-1:0] sync_q,
  input logic [PINS-1:0] prev_q,
  input logic [PINS-1:0] lvl_q,
  input logic [PINS-1:0] dual_q,
  input logic [PINS-1:0] pol_q,
  input logic [PINS-1:0] evt,
  input logic [PINS-1:0] stat_q,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] pad_pull_up,
  input logic [PINS-1:0] pad_pull_dn,
  input logic            irq
);
  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && pin_oe == '0 && stat_q == '0));

  a_r5_dual_latches: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(dual_q & ~lvl_q & (sync_q ^ prev_q)) & ~stat_q) == '0));

  a_r6_level_holds: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(lvl_q & ~(sync_q ^ pol_q)) & ~stat_q) == '0));

  a_r7_no_phantom: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));

  a_r10_bias_excl: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_up & pad_pull_dn) == '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PINS(PINS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sync_q      (sync_q),
  .prev_q      (prev_q),
  .lvl_q       (lvl_q),
  .dual_q      (dual_q),
  .pol_q       (pol_q),
  .evt         (evt),
  .stat_q      (stat_q),
  .pin_oe      (pin_oe),
  .pad_pull_up (pad_pull_up),
  .pad_pull_dn (pad_pull_dn),
  .irq         (irq)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pad_pull_up, pad_pull_dn;
  logic [95:0] pad_drive;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .pad_drive(pad_drive), .irq(irq)
  );

  // ---------------- reference model built from the requirements -------------
  logic [31:0] m_pl [11];
  logic [31:0] m_s1, m_s2, m_pv, m_stat, m_rd;
  logic        m_irq;

  function automatic int plane_idx(input logic [7:0] a);
    if (a[1:0] != 2'b00) return -1;
    case (a)
      8'h04: return 0;  8'h08: return 1;  8'h0C: return 2;  8'h10: return 3;
      8'h14: return 4;  8'h18: return 5;  8'h34: return 6;  8'h38: return 7;
      8'h58: return 8;  8'h5C: return 9;  8'h60: return 10;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] ev_f(input logic [31:0] s, p, lv, du, po);
    return (lv & ~(s ^ po)) |
           (~lv & ((du & (s ^ p)) | (~du & ((po & s & ~p) | (~po & ~s & p)))));
  endfunction

  function automatic logic [31:0] rd_f(input logic [7:0] a);
    int k;
    k = plane_idx(a);
    if (k >= 0)   return m_pl[k];
    if (a == 8'h00) return m_s2;
    if (a == 8'h1C) return m_stat;
    if (a == 8'h20) return m_stat & m_pl[5];
    return '0;
  endfunction

  function automatic logic [95:0] drv_f();
    logic [95:0] d;
    for (int i = 0; i < 32; i++) d[3*i +: 3] = {m_pl[10][i], m_pl[9][i], m_pl[8][i]};
    return d;
  endfunction

  always @(posedge clk) begin
    logic [31:0] clr;
    int k;
    if (rst) begin
      for (int j = 0; j < 11; j++) m_pl[j] <= '0;
      m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_stat <= '0; m_rd <= '0; m_irq <= 1'b0;
    end else begin
      clr = (bus_sel && bus_wr && bus_addr == 8'h24) ? bus_wdata : '0;
      m_s1 <= pin_in; m_s2 <= m_s1; m_pv <= m_s2;
      m_stat <= (m_stat & ~clr) | ev_f(m_s2, m_pv, m_pl[2], m_pl[3], m_pl[4]);
      m_irq <= |(m_stat & m_pl[5]);
      m_rd <= (bus_sel && !bus_wr) ? rd_f(bus_addr) : '0;
      k = plane_idx(bus_addr);
      if (bus_sel && bus_wr && k >= 0) m_pl[k] <= bus_wdata;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R2 pin_out", pin_out, m_pl[0]);
      chk("R2 pin_oe", pin_oe, m_pl[1]);
      chk("R10 pad_pull_up", pad_pull_up, m_pl[7] & m_pl[6]);
      chk("R10 pad_pull_dn", pad_pull_dn, m_pl[7] & ~m_pl[6]);
      chk("R11 pad_drive", pad_drive, drv_f());
      chk("R9 irq", irq, m_irq);
      chk("R3 R7 R9 R12 bus_rdata", bus_rdata, m_rd);
    end
  end

  // ---------------- bus and pin helpers -------------------------------------
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  localparam logic [7:0] ADDRS [16] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
    8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h34, 8'h38, 8'h58, 8'h5C, 8'h61};

  // ---------------- watchdog ------------------------------------------------
  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- main sequence -------------------------------------------
  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    model_on = 1'b1;

    // R1: reset state
    chk("R1 irq", irq, 1'b0);
    chk("R1 pad_drive", pad_drive, '0);
    for (int i = 1; i < 16; i++) begin
      bus_read(ADDRS[i], r);
      chk("R1 register zero", r, '0);
    end

    // R2: direction and output data
    bus_write(8'h08, 32'hA5A5_0F0F);
    bus_write(8'h04, 32'h1234_5678);
    chk("R2 pin_oe", pin_oe, 32'hA5A5_0F0F);
    chk("R2 pin_out", pin_out, 32'h1234_5678);
    bus_read(8'h08, r);
    chk("R2 readback", r, 32'hA5A5_0F0F);

    // R11: drive code planes; pin0 -> 3'b101, pin1 -> 3'b001
    bus_write(8'h58, 32'hFFFF_FFFF);
    bus_write(8'h60, 32'h0000_0001);
    chk("R11 pin0 code", pad_drive[2:0], 3'd5);
    chk("R11 pin1 code", pad_drive[5:3], 3'd1);

    // R10: pin0 up, pin1 down, pin2 direction up but disabled
    bus_write(8'h34, 32'h0000_0005);
    bus_write(8'h38, 32'h0000_0003);
    chk("R10 pull up", pad_pull_up[2:0], 3'b001);
    chk("R10 pull dn", pad_pull_dn[2:0], 3'b010);

    // interrupt setup: pin0 rising, pin1 level high, pin2 dual, pin3 falling
    bus_write(8'h14, 32'h0000_0003);
    bus_write(8'h0C, 32'h0000_0002);
    bus_write(8'h10, 32'h0000_0004);
    bus_write(8'h18, 32'h0000_0001);
    bus_write(8'h24, 32'hFFFF_FFFF);
    idle(2);
    bus_read(8'h1C, r);
    chk("R4 quiet status", r, '0);

    // R8: clear lands in the same cycle as pin0's rising edge
    @(negedge clk);
    pin_in = 32'h1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h24; bus_wdata = 32'h1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(8'h1C, r);
    chk("R8 event beats clear", r, 32'h1);
    chk("R9 irq high", irq, 1'b1);
    bus_read(8'h20, r);
    chk("R9 masked status", r, 32'h1);
    bus_write(8'h24, 32'h1);
    idle(1);
    bus_read(8'h1C, r);
    chk("R7 clear works", r, '0);
    chk("R9 irq low", irq, 1'b0);

    // R6: level-high pin1
    set_pins(32'h3);
    idle(4);
    bus_read(8'h1C, r);
    chk("R6 level set", r, 32'h2);
    bus_write(8'h24, 32'h2);
    bus_read(8'h1C, r);
    chk("R6 clear while active", r, 32'h2);
    set_pins(32'h1);
    idle(4);
    bus_read(8'h1C, r);
    chk("R6 latched after release", r, 32'h2);
    bus_write(8'h24, 32'h2);
    bus_read(8'h1C, r);
    chk("R6 clear after release", r, '0);

    // R5: dual-edge pin2 with polarity 0
    set_pins(32'h5);
    idle(4);
    bus_read(8'h1C, r);
    chk("R5 rising", r, 32'h4);
    bus_write(8'h24, 32'h4);
    set_pins(32'h1);
    idle(4);
    bus_read(8'h1C, r);
    chk("R5 falling", r, 32'h4);
    bus_write(8'h24, 32'h4);

    // R4: falling-edge pin3
    set_pins(32'h9);
    idle(4);
    bus_read(8'h1C, r);
    chk("R4 rise ignored", r, '0);
    set_pins(32'h1);
    idle(4);
    bus_read(8'h1C, r);
    chk("R4 fall latched", r, 32'h8);

    // R7: zero bits of a clear keep status; clear register reads 0
    bus_write(8'h24, 32'h4);
    bus_read(8'h1C, r);
    chk("R7 zero bits kept", r, 32'h8);
    bus_write(8'h24, 32'h8);
    bus_read(8'h24, r);
    chk("R7 clear reads zero", r, '0);

    // R3: input read and read-only writes
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_read(8'h00, r);
    chk("R3 input data", r, 32'h1);
    bus_read(8'h1C, r);
    chk("R3 raw write ignored", r, '0);

    // R12: unmapped and misaligned
    bus_read(8'h28, r);
    chk("R12 unmapped read", r, '0);
    bus_read(8'h61, r);
    chk("R12 misaligned read", r, '0);
    bus_write(8'h05, 32'hFFFF_FFFF);
    bus_read(8'h04, r);
    chk("R12 misaligned write ignored", r, 32'h1234_5678);

    // random traffic, compared every cycle against the model
    for (int c = 0; c < 4000; c++) begin
      int op;
      @(negedge clk);
      if ($urandom % 4 == 0)
        pin_in = pin_in ^ (($urandom % 8 == 0) ? $urandom : (32'h1 << ($urandom % 32)));
      op = $urandom % 10;
      bus_addr  = ADDRS[$urandom % 16];
      bus_wdata = $urandom;
      if (op < 4)      begin bus_sel = 1'b0; bus_wr = 1'b0; end
      else if (op < 7) begin bus_sel = 1'b1; bus_wr = 1'b1; end
      else if (op < 8) begin bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h24; end
      else             begin bus_sel = 1'b1; bus_wr = 1'b0; end
    end
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    idle(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule